// File: doc/BRIEF.md
# Lockable Double-Buffered PWM Timer

This block is a single-channel pulse-width modulator controlled through a small 32-bit word-register bus. A free-running counter steps once per clock from zero up to one below the programmed period and then wraps. While the count is below the programmed duty, the output sits at its active level. For the rest of the period it sits at the opposite level. When the channel is stopped, the output rests at a separately programmable idle level.

Software never writes the running waveform directly. Period, duty and both polarity bits are first written into pending registers. They move into the active set only at a period boundary, so a running waveform never has a glitch in the middle of a period.

For updates that must land together, software sets a lock bit, writes the new period, duty and polarity, and then clears the lock. The whole group then takes effect at the first wrap after the lock is cleared.

Top module: `pwm_lock_timer`

## Requirements
- R1: After reset the control word reads 0x18, period, duty and counter read 0, and `pwm_out` is high.
- R2: The channel runs only when control bit 0 is 1 and control bits 2:1 equal 01. While running, the counter steps 0, 1, …, period-1 and wraps to 0. With a period of 0 or 1 it stays at 0.
- R3: While running, `pwm_out` is at the active level when counter < duty, and at the opposite level otherwise. The active level is high when control bit 3 is 1 and low when it is 0. This means duty ≥ period gives a constant active output and duty 0 gives a constant non-active output.
- R4: With the lock clear, writes to period, duty or control bit 3 take effect only at the next counter wrap, never in the middle of a period.
- R5: While control bit 6 (lock) is 1, new period, duty and polarity values are held back. After the lock is cleared, all of them take effect together at the next wrap.
- R6: Clearing bit 0, or setting a mode other than 01, stops the channel. On the next clock the counter is 0 and `pwm_out` is at the idle level.
- R7: The idle level is high when control bit 4 is 1 and low when it is 0. While stopped and unlocked, a change to it reaches `pwm_out` within two clocks of the write.
- R8: The word registers sit at byte offsets 0x0 (counter), 0x4 (period), 0x8 (duty) and 0xC (control). The counter is read-only. Writes to unaligned addresses are ignored. Control bits 5 (alignment, 0 = left) and 8 (low-power off) are stored, and bit 7 and bits 31:9 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one count per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Byte address of the word register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pwm_out | output | 1 | Registered PWM output |

## Verification
The hardest case to reach is a lock release that races a running period. Here the pending values must stay invisible for several full periods and then switch over all together at exactly one wrap.

The bench drives this case directly. It locks the channel, writes a new period, duty and polarity one word at a time, and runs several old periods while checking every cycle against the old settings. It then unlocks and keeps checking until the switch.

A reference model in the bench holds the new settings as "armed". It applies them at the first observed counter value of 0 after the enabling write completes, so an early or late switch at any wrap shows up as a mismatch.

// File: rtl/pwm_lock_pkg.sv
package pwm_lock_pkg;

    localparam int unsigned ADDR_W = 4;

    localparam logic [1:0] REG_COUNT  = 2'd0;
    localparam logic [1:0] REG_PERIOD = 2'd1;
    localparam logic [1:0] REG_DUTY   = 2'd2;
    localparam logic [1:0] REG_CTRL   = 2'd3;

    localparam logic [1:0] MODE_CONT = 2'b01;

    typedef struct packed {
        logic       lp_off;    // bit 8
        logic       lock;      // bit 6
        logic       align;     // bit 5
        logic       idle_pol;  // bit 4
        logic       duty_pol;  // bit 3
        logic [1:0] mode;      // bits 2:1
        logic       en;        // bit 0
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{lp_off: 1'b0, lock: 1'b0, align: 1'b0,
                                   idle_pol: 1'b1, duty_pol: 1'b1,
                                   mode: 2'b00, en: 1'b0};

    function automatic ctrl_t ctrl_unpack(input logic [31:0] w);
        ctrl_t c;
        c.en       = w[0];
        c.mode     = w[2:1];
        c.duty_pol = w[3];
        c.idle_pol = w[4];
        c.align    = w[5];
        c.lock     = w[6];
        c.lp_off   = w[8];
        return c;
    endfunction

    function automatic logic [31:0] ctrl_pack(input ctrl_t c);
        logic [31:0] w;
        w      = '0;
        w[0]   = c.en;
        w[2:1] = c.mode;
        w[3]   = c.duty_pol;
        w[4]   = c.idle_pol;
        w[5]   = c.align;
        w[6]   = c.lock;
        w[8]   = c.lp_off;
        return w;
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_lock_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt_val,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  period_pend,
    output logic [CNT_W-1:0]  duty_pend,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned WORD_LSB = 2;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] duty;
    } regs_t;

    regs_t st_d, st_q;
    logic  aligned;
    logic [1:0] word_sel;

    assign aligned  = (addr[WORD_LSB-1:0] == '0);
    assign word_sel = addr[ADDR_W-1:WORD_LSB];

    always_comb begin
        st_d = st_q;
        if (wr_en && aligned) begin
            case (word_sel)
                REG_PERIOD: st_d.period = wdata[CNT_W-1:0];
                REG_DUTY:   st_d.duty   = wdata[CNT_W-1:0];
                REG_CTRL:   st_d.ctrl   = ctrl_unpack(wdata);
                default:    st_d        = st_q;   // counter is read-only
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl   <= CTRL_RST;
            st_q.period <= '0;
            st_q.duty   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (word_sel)
            REG_COUNT:  rdata[CNT_W-1:0] = cnt_val;
            REG_PERIOD: rdata[CNT_W-1:0] = st_q.period;
            REG_DUTY:   rdata[CNT_W-1:0] = st_q.duty;
            default:    rdata            = ctrl_pack(st_q.ctrl);
        endcase
    end

    assign ctrl        = st_q.ctrl;
    assign period_pend = st_q.period;
    assign duty_pend   = st_q.duty;

endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] period_in,
    input  logic [CNT_W-1:0] duty_in,
    input  logic             dpol_in,
    input  logic             ipol_in,
    output logic [CNT_W-1:0] period_q,
    output logic [CNT_W-1:0] duty_q,
    output logic             dpol_q,
    output logic             ipol_q,
    output logic [CNT_W-1:0] duty_nx,
    output logic             dpol_nx,
    output logic             ipol_nx
);

    typedef struct packed {
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] duty;
        logic             dpol;
        logic             ipol;
    } act_t;

    act_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.period = period_in;
            st_d.duty   = duty_in;
            st_d.dpol   = dpol_in;
            st_d.ipol   = ipol_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.period <= '0;
            st_q.duty   <= '0;
            st_q.dpol   <= 1'b1;
            st_q.ipol   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign period_q = st_q.period;
    assign duty_q   = st_q.duty;
    assign dpol_q   = st_q.dpol;
    assign ipol_q   = st_q.ipol;
    assign duty_nx  = st_d.duty;
    assign dpol_nx  = st_d.dpol;
    assign ipol_nx  = st_d.ipol;

endmodule

// File: rtl/pwm_core.sv
module pwm_core #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_req,
    input  logic [CNT_W-1:0] period_q,
    input  logic [CNT_W-1:0] duty_nx,
    input  logic             dpol_nx,
    input  logic             ipol_nx,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             boundary,
    output logic             pwm_out
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             out;
    } core_t;

    core_t st_d, st_q;
    logic  wrap;

    // a period ends when the next count would reach the period value
    assign wrap     = st_q.run && (({1'b0, st_q.cnt} + 1'b1) >= {1'b0, period_q});
    assign boundary = !st_q.run || wrap;

    always_comb begin
        st_d     = st_q;
        st_d.run = run_req;
        if (run_req && st_q.run && !wrap) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else begin
            st_d.cnt = '0;
        end
        if (run_req) begin
            st_d.out = (st_d.cnt < duty_nx) ? dpol_nx : !dpol_nx;
        end else begin
            st_d.out = ipol_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.run <= 1'b0;
            st_q.out <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt     = st_q.cnt;
    assign running = st_q.run;
    assign pwm_out = st_q.out;

endmodule

// File: rtl/pwm_lock_timer.sv
module pwm_lock_timer
    import pwm_lock_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pwm_out
);

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] period_pend, duty_pend;
    logic [CNT_W-1:0] act_period, act_duty, duty_nx;
    logic             act_dpol, act_ipol, dpol_nx, ipol_nx;
    logic [CNT_W-1:0] core_cnt;
    logic             core_run, core_boundary;
    logic             run_req, shadow_load, lock_bit;

    assign lock_bit    = ctrl_q.lock;
    assign run_req     = ctrl_q.en && (ctrl_q.mode == MODE_CONT);
    assign shadow_load = core_boundary && !lock_bit;

    pwm_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (bus_wr_en),
        .addr        (bus_addr),
        .wdata       (bus_wdata),
        .cnt_val     (core_cnt),
        .ctrl        (ctrl_q),
        .period_pend (period_pend),
        .duty_pend   (duty_pend),
        .rdata       (bus_rdata)
    );

    pwm_shadow #(.CNT_W(CNT_W)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (shadow_load),
        .period_in (period_pend),
        .duty_in   (duty_pend),
        .dpol_in   (ctrl_q.duty_pol),
        .ipol_in   (ctrl_q.idle_pol),
        .period_q  (act_period),
        .duty_q    (act_duty),
        .dpol_q    (act_dpol),
        .ipol_q    (act_ipol),
        .duty_nx   (duty_nx),
        .dpol_nx   (dpol_nx),
        .ipol_nx   (ipol_nx)
    );

    pwm_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_req  (run_req),
        .period_q (act_period),
        .duty_nx  (duty_nx),
        .dpol_nx  (dpol_nx),
        .ipol_nx  (ipol_nx),
        .cnt      (core_cnt),
        .running  (core_run),
        .boundary (core_boundary),
        .pwm_out  (pwm_out)
    );

endmodule

// File: rtl/pwm_lock_chk.sv
module pwm_lock_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              pwm_out,
    input logic              lock_bit,
    input logic              core_run,
    input logic [CNT_W-1:0]  core_cnt,
    input logic [CNT_W-1:0]  act_period,
    input logic [CNT_W-1:0]  act_duty,
    input logic              act_dpol,
    input logic              act_ipol
);

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (core_run && act_period > 1) |-> (core_cnt < act_period)); // R2

    AST_OUT_FOLLOWS_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        core_run |-> (pwm_out == ((core_cnt < act_duty) ? act_dpol : !act_dpol))); // R3

    AST_NO_MIDPERIOD_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (core_run && core_cnt != '0) |-> ($stable(act_duty) && $stable(act_period) && $stable(act_dpol))); // R4

    AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        lock_bit |=> ($stable(act_period) && $stable(act_duty) && $stable(act_dpol))); // R5

    AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(core_run) |-> (core_cnt == '0 && pwm_out == act_ipol)); // R6

    AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 4'hC) |-> (bus_rdata[7] == 1'b0 && bus_rdata[DATA_W-1:9] == '0)); // R8

endmodule

bind pwm_lock_timer pwm_lock_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_pwm_lock_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .pwm_out    (pwm_out),
    .lock_bit   (lock_bit),
    .core_run   (core_run),
    .core_cnt   (core_cnt),
    .act_period (act_period),
    .act_duty   (act_duty),
    .act_dpol   (act_dpol),
    .act_ipol   (act_ipol)
);

// File: tb/test_pwm_lock_timer.sv
module test_pwm_lock_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    int checks = 0;
    int fails  = 0;

    // reference model: active and pending settings
    int unsigned m_per = 0, m_duty = 0;
    bit          m_pol = 1'b1;
    int unsigned p_per = 0, p_duty = 0;
    bit          p_pol = 1'b1;
    bit          m_armed = 1'b0;

    always #5 clk = ~clk;

    pwm_lock_timer i_pwm_lock_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr_en (bus_wr_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    function automatic logic [31:0] mk_ctrl(bit en, bit [1:0] mode, bit dpol, bit ipol, bit lock);
        return {23'd0, 1'b0, 1'b0, lock, 1'b0, ipol, dpol, mode, en};
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
        bus_addr  = 4'h0;
        bus_wdata = '0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = 4'h0;
    endtask

    // checks counter sequence and output every cycle against the model
    task automatic run_win(int n, string tag);
        int          prev = -1;
        int unsigned per_prev = m_per;
        int unsigned c;
        bit          exp_o;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            c = bus_rdata;
            if (m_armed && c == 0) begin
                m_per = p_per; m_duty = p_duty; m_pol = p_pol;
                m_armed = 1'b0;
            end
            if (prev >= 0) begin
                int unsigned exp_c;
                exp_c = (prev + 1 >= per_prev) ? 0 : prev + 1;
                chk(c == exp_c, {"R2 counter ", tag}, c, exp_c);
            end
            exp_o = (c < m_duty) ? m_pol : !m_pol;
            chk(pwm_out == exp_o, {"R3 output ", tag}, pwm_out, exp_o);
            prev = int'(c);
            per_prev = m_per;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        @(negedge clk);
        chk(pwm_out == 1'b1, "R1 output after reset", pwm_out, 1);
        rd(4'hC, d); chk(d == 32'h18, "R1 ctrl reset", d, 32'h18);
        rd(4'h4, d); chk(d == 0, "R1 period reset", d, 0);
        rd(4'h8, d); chk(d == 0, "R1 duty reset", d, 0);
        rd(4'h0, d); chk(d == 0, "R1 counter reset", d, 0);
    endtask

    task automatic t_basic();
        wr(4'h4, 5);
        wr(4'h8, 2);
        wr(4'hC, mk_ctrl(1, 2'b01, 1, 1, 0));
        @(negedge clk);
        chk(bus_rdata == 0, "R2 counter at start", bus_rdata, 0);
        chk(pwm_out == 1'b1, "R3 first cycle active", pwm_out, 1);
        m_per = 5; m_duty = 2; m_pol = 1;
        p_per = 5; p_duty = 2; p_pol = 1;
        run_win(15, "basic");
    endtask

    task automatic t_midperiod();
        int guard = 0;
        while (bus_rdata != 2 && guard < 20) begin
            @(negedge clk);
            guard++;
        end
        wr(4'h8, 4); p_duty = 4; m_armed = 1'b1;
        run_win(12, "R4 duty mid-period");
        wr(4'h4, 3); p_per = 3; m_armed = 1'b1;
        run_win(10, "R3 duty above period");
        wr(4'h8, 0); p_duty = 0; m_armed = 1'b1;
        run_win(8, "R3 zero duty");
        wr(4'h4, 6); p_per = 6; m_armed = 1'b1;
        run_win(10, "R4 period change");
        wr(4'h8, 2); p_duty = 2; m_armed = 1'b1;
        run_win(10, "R4 duty change");
    endtask

    task automatic t_polarity();
        wr(4'hC, mk_ctrl(1, 2'b01, 0, 1, 0)); p_pol = 0; m_armed = 1'b1;
        run_win(14, "R3 active-low");
    endtask

    task automatic t_lock();
        wr(4'hC, mk_ctrl(1, 2'b01, 0, 1, 1));
        wr(4'h4, 8);
        wr(4'h8, 6);
        wr(4'hC, mk_ctrl(1, 2'b01, 1, 1, 1));
        run_win(20, "R5 while locked");
        wr(4'hC, mk_ctrl(1, 2'b01, 1, 1, 0));
        p_per = 8; p_duty = 6; p_pol = 1; m_armed = 1'b1;
        run_win(24, "R5 after release");
    endtask

    task automatic t_disable();
        wr(4'hC, mk_ctrl(0, 2'b01, 1, 1, 0));
        @(negedge clk);
        chk(bus_rdata == 0, "R6 counter cleared", bus_rdata, 0);
        chk(pwm_out == 1'b1, "R6 idle level high", pwm_out, 1);
        wr(4'hC, mk_ctrl(0, 2'b01, 1, 0, 0));
        @(negedge clk);
        chk(pwm_out == 1'b0, "R7 idle level low", pwm_out, 0);
        repeat (4) @(negedge clk);
        chk(pwm_out == 1'b0, "R7 idle level held", pwm_out, 0);
        chk(bus_rdata == 0, "R6 counter held at 0", bus_rdata, 0);
    endtask

    task automatic t_mode();
        logic [31:0] d;
        wr(4'hC, mk_ctrl(1, 2'b10, 1, 1, 0));
        repeat (5) @(negedge clk);
        chk(pwm_out == 1'b1, "R6 bad mode stays idle", pwm_out, 1);
        chk(bus_rdata == 0, "R6 bad mode counter 0", bus_rdata, 0);
        wr(4'h0, 9);
        rd(4'h0, d); chk(d == 0, "R8 counter read-only", d, 0);
    endtask

    task automatic t_map();
        logic [31:0] d;
        wr(4'h4, 32'h1234);
        rd(4'h4, d); chk(d == 32'h1234, "R8 period offset", d, 32'h1234);
        wr(4'h8, 32'h0BEE);
        rd(4'h8, d); chk(d == 32'h0BEE, "R8 duty offset", d, 32'h0BEE);
        wr(4'h5, 32'h99);
        rd(4'h4, d); chk(d == 32'h1234, "R8 unaligned write ignored", d, 32'h1234);
        wr(4'hC, 32'hFFFF_FFFF);
        rd(4'hC, d); chk(d == 32'h17F, "R8 ctrl stored bits", d, 32'h17F);
    endtask

    initial begin : watchdog
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_midperiod();
        t_polarity();
        t_lock();
        t_disable();
        t_mode();
        t_map();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule